// File: doc/BRIEF.md
# Lower-Part OR Approximate Adder

This block adds two unsigned operands of `N` bits while spending carry logic on only the top `N-L` bit positions. The bottom `L` bit positions produce their sum bits with a single OR gate per position and keep no carry chain at all. The upper slice is an exact adder. The only link from the lower slice to the upper slice is a guessed carry. That guess is the AND of the two operand bits at position `L-1`.

The block is purely combinational. It is meant for datapaths that tolerate small errors, such as filters, image pipelines and accumulators. In those paths the critical path may then start at one AND gate and run only through the upper adder. The error is always confined to a window of size `2^(L-1)`. Its sign follows the carry guess. Setting `L` to zero turns the block into an ordinary exact adder.

Parameters: `N` is the operand width. `L` is the width of the approximate lower slice, with `0 <= L < N`.

Top module: `orlow_approx_adder`

## Requirements
- R1: For every bit position i below L, `sum_o[i]` equals `a_i[i] | b_i[i]`.
- R2: When L > 0, `{cout_o, sum_o[N-1:L]}` equals `a_i[N-1:L] + b_i[N-1:L] + (a_i[L-1] & b_i[L-1])`, with the addition taken exactly.
- R3: Changing operand bits at positions below L-1 leaves `cout_o` and `sum_o[N-1:L]` unchanged, because no carry leaves those positions.
- R4: With L = 0, `{cout_o, sum_o}` equals the exact (N+1)-bit sum `a_i + b_i`.
- R5: When no lower-slice position has both operand bits set, that is when `(a_i & b_i)` over bits L-1..0 is zero, `{cout_o, sum_o}` equals the exact sum.
- R6: The error distance between `{cout_o, sum_o}` and the exact sum never exceeds 2^(L-1) for L > 0.
- R7: When `a_i[L-1] & b_i[L-1]` is 1, the result is never below the exact sum. When it is 0, the result is never above the exact sum.
- R8: With L = N-1, the upper slice is one bit wide, and `{cout_o, sum_o[N-1]}` equals `a_i[N-1] + b_i[N-1] + (a_i[N-2] & b_i[N-2])`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First unsigned operand |
| b_i | input | N | Second unsigned operand |
| sum_o | output | N | Approximate sum, low L bits from OR gates |
| cout_o | output | 1 | Carry out of the exact upper slice |

## Verification
The bound checker re-evaluates the block on every input change. It confirms the OR rule on the lower slice and the exact upper sum with its guessed carry. It also confirms exactness when the lower slice has no overlapping ones, and it confirms both the bound and the sign of the error against a plain wide addition. Some properties can only be shown by the bench's scenarios, because each one needs several stimuli or more than one parameter setting. These are the insensitivity of the upper result to the bits below position L-1, the L = 0 exact configuration, and the single-bit upper slice at L = N-1. The bench also tallies how many random results differ from the exact sum and how large the mean error is.

// File: rtl/orlow_pkg.sv
// Package: shared helpers for the lower-part OR approximate adder.
// Assumes widths are small enough for a 32-bit int.
package orlow_pkg;

    // Number of prefix-combine levels needed to span w bit positions.
    function automatic int unsigned prefix_levels(input int unsigned w);
        int unsigned lv;
        lv = 0;
        while ((32'd1 << lv) < w) begin
            lv = lv + 1;
        end
        return lv;
    endfunction

endpackage

// File: rtl/orlow_lower_or.sv
// Module: orlow_lower_or
// Produces the approximate low sum bits with one OR gate per position.
// No carry is formed or consumed here. Assumes W >= 1.
module orlow_lower_or #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);

    // One OR per bit position, no interaction between positions.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i] = a_i[i] | b_i[i];
    end

endmodule

// File: rtl/orlow_carry_guess.sv
// Module: orlow_carry_guess
// Forms the speculated carry into the exact upper slice from the two
// most significant lower-slice operand bits. Single AND level.
module orlow_carry_guess (
    input  logic a_top_i,
    input  logic b_top_i,
    output logic carry_o
);

    // Carry is guessed only when both top lower bits are set.
    assign carry_o = a_top_i & b_top_i;

endmodule

// File: rtl/orlow_prefix_adder.sv
// Module: orlow_prefix_adder
// Exact W-bit adder with carry-in, built as a Kogge-Stone parallel prefix
// network of ceil(log2(W)) levels. Assumes W >= 1.
module orlow_prefix_adder
    import orlow_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    localparam int unsigned LV = prefix_levels(W);

    logic [W:0] carry;

    // Prefix levels: level 0 holds bit generate/propagate, later levels
    // merge groups at distance 2^(k-1).
    for (genvar k = 0; k <= LV; k++) begin : stage
        logic [W-1:0] g;
        logic [W-1:0] p;
        if (k == 0) begin : g_init
            // Bit-level generate and propagate.
            assign g = a_i & b_i;
            assign p = a_i ^ b_i;
        end else begin : g_merge
            localparam int unsigned DIST = 32'd1 << (k - 1);
            for (genvar i = 0; i < W; i++) begin : g_pos
                if (i >= DIST) begin : g_comb
                    // Merge this group with the one DIST positions below.
                    assign g[i] = stage[k-1].g[i] | (stage[k-1].p[i] & stage[k-1].g[i-DIST]);
                    assign p[i] = stage[k-1].p[i] & stage[k-1].p[i-DIST];
                end else begin : g_pass
                    // Nothing below to merge with: pass unchanged.
                    assign g[i] = stage[k-1].g[i];
                    assign p[i] = stage[k-1].p[i];
                end
            end
        end
    end

    // Carries into each position: group terms from bit 0 combined with carry-in.
    assign carry[0]   = cin_i;
    assign carry[W:1] = stage[LV].g | (stage[LV].p & {W{cin_i}});

    // Sum bits and carry-out.
    assign sum_o  = stage[0].p ^ carry[W-1:0];
    assign cout_o = carry[W];

endmodule

// File: rtl/orlow_approx_adder.sv
// Module: orlow_approx_adder (top)
// N-bit unsigned adder. The low L positions are approximated by OR gates,
// and the upper N-L positions are added exactly with a carry-in guessed
// from the AND of operand bits L-1. Combinational. Assumes 0 <= L < N.
module orlow_approx_adder #(
    parameter int unsigned N = 16,
    parameter int unsigned L = 4
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);

    localparam int unsigned HI_W = N - L;

    logic            hi_cin;
    logic [HI_W-1:0] hi_sum;

    if (L > 0) begin : g_approx
        logic [L-1:0] lo_sum;

        // Approximate lower slice.
        orlow_lower_or #(.W(L)) lower_i (
            .a_i   (a_i[L-1:0]),
            .b_i   (b_i[L-1:0]),
            .sum_o (lo_sum)
        );

        // Carry speculation from the top lower-slice bits.
        orlow_carry_guess guess_i (
            .a_top_i (a_i[L-1]),
            .b_top_i (b_i[L-1]),
            .carry_o (hi_cin)
        );

        // Place lower slice into the result.
        assign sum_o[L-1:0] = lo_sum;
    end else begin : g_exact
        // No lower slice: plain exact adder with zero carry-in.
        assign hi_cin = 1'b0;
    end

    // Exact upper slice.
    orlow_prefix_adder #(.W(HI_W)) upper_i (
        .a_i    (a_i[N-1:L]),
        .b_i    (b_i[N-1:L]),
        .cin_i  (hi_cin),
        .sum_o  (hi_sum),
        .cout_o (cout_o)
    );

    // Place upper slice into the result.
    assign sum_o[N-1:L] = hi_sum;

endmodule

// File: rtl/orlow_approx_adder_chk.sv
// Module: orlow_approx_adder_chk
// Port-level checker bound into every orlow_approx_adder instance.
// Re-evaluates the arithmetic rules whenever operands or results change.
module orlow_approx_adder_chk #(
    parameter int unsigned N = 16,
    parameter int unsigned L = 4
) (
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic [N-1:0] sum_i,
    input logic         cout_i
);

    logic [N:0] exact_w;
    logic [N:0] approx_w;

    // Wide reference and observed results.
    assign exact_w  = {1'b0, a_i} + {1'b0, b_i};
    assign approx_w = {cout_i, sum_i};

    if (L > 0) begin : g_approx
        localparam int unsigned HI_W = N - L;
        logic [N:0]      half_w;
        logic            guess;
        logic [HI_W:0]   hi_ref;
        logic [L-1:0]    overlap;

        assign half_w  = (N+1)'(1) << (L - 1);
        assign guess   = a_i[L-1] & b_i[L-1];
        assign hi_ref  = {1'b0, a_i[N-1:L]} + {1'b0, b_i[N-1:L]} + {{HI_W{1'b0}}, guess};
        assign overlap = a_i[L-1:0] & b_i[L-1:0];

        // Arithmetic rules on the approximate configuration.
        always_comb begin
            a_r1_low_or: assert (sum_i[L-1:0] == (a_i[L-1:0] | b_i[L-1:0]))
                else $error("R1 low slice is not the OR of the operands");
            a_r2_upper_exact: assert ({cout_i, sum_i[N-1:L]} == hi_ref)
                else $error("R2 upper slice differs from exact sum with guessed carry");
            a_r5_no_overlap_exact: assert (overlap != '0 || approx_w == exact_w)
                else $error("R5 result inexact with no overlapping lower ones");
            a_r6_ed_bound: assert ((approx_w >= exact_w) ? (approx_w - exact_w <= half_w)
                                                         : (exact_w - approx_w <= half_w))
                else $error("R6 error distance beyond half lower range");
            a_r7_error_sign: assert (guess ? (approx_w >= exact_w) : (approx_w <= exact_w))
                else $error("R7 error sign disagrees with carry guess");
        end
    end else begin : g_exact
        // Exact configuration.
        always_comb begin
            a_r4_exact_mode: assert (approx_w == exact_w)
                else $error("R4 exact configuration result differs");
        end
    end

endmodule

bind orlow_approx_adder orlow_approx_adder_chk #(.N(N), .L(L)) chk_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_i  (sum_o),
    .cout_i (cout_o)
);

// File: tb/orlow_approx_adder_tb_top.sv
// Bench: three configurations share operands. The main one has L=4, the
// exact one L=0 and the wide one L=N-1. Expected values come from
// bench functions.
module orlow_approx_adder_tb_top;

    localparam int N  = 16;
    localparam int LM = 4;
    localparam int LW = N - 1;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic [N-1:0] sum_m, sum_e, sum_w;
    logic         cout_m, cout_e, cout_w;

    int n_cmp = 0;
    int n_bad = 0;
    int err_cnt = 0;
    longint unsigned ed_sum = 0;
    real rel_sum = 0.0;
    int  rel_n = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    orlow_approx_adder #(.N(N), .L(LM)) dut_i (
        .a_i(a), .b_i(b), .sum_o(sum_m), .cout_o(cout_m));
    orlow_approx_adder #(.N(N), .L(0)) dut_exact_i (
        .a_i(a), .b_i(b), .sum_o(sum_e), .cout_o(cout_e));
    orlow_approx_adder #(.N(N), .L(LW)) dut_wide_i (
        .a_i(a), .b_i(b), .sum_o(sum_w), .cout_o(cout_w));

    // Model per R1/R2: low bits ORed, upper exact with AND-guessed carry.
    function automatic logic [63:0] model(input logic [63:0] x, input logic [63:0] y, input int l);
        logic [63:0] mask, low, c, hi;
        mask = (64'd1 << l) - 64'd1;
        low  = (x | y) & mask;
        c    = (l > 0) ? ((x >> (l - 1)) & (y >> (l - 1)) & 64'd1) : 64'd0;
        hi   = (x >> l) + (y >> l) + c;
        return (hi << l) | low;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (a=%0h b=%0h)", tag, act, exp, a, b);
        end
    endtask

    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y);
        @(negedge clk);
        a = x;
        b = y;
        #2;
    endtask

    // Full set of checks on one operand pair.
    task automatic run_vec(input logic [N-1:0] x, input logic [N-1:0] y);
        logic [63:0] act_m, exp_m, exact, ed;
        logic        guess;
        apply(x, y);
        act_m = 64'({cout_m, sum_m});
        exp_m = model(64'(x), 64'(y), LM);
        exact = 64'(x) + 64'(y);
        guess = x[LM-1] & y[LM-1];
        check("R1 low OR", act_m & 64'hF, exp_m & 64'hF);
        check("R2 upper exact", act_m >> LM, exp_m >> LM);
        check("R4 exact config", 64'({cout_e, sum_e}), exact);
        check("R8 one-bit upper", 64'({cout_w, sum_w}), model(64'(x), 64'(y), LW));
        if (((x & y) & 16'h000F) == 16'h0) check("R5 no overlap exact", act_m, exact);
        ed = (act_m >= exact) ? act_m - exact : exact - act_m;
        check("R6 ed bound", 64'(ed <= 64'd8), 64'd1);
        check("R7 error sign", 64'(guess ? (act_m >= exact) : (act_m <= exact)), 64'd1);
        // Error-metric monitor.
        if (act_m != exact) begin
            err_cnt++;
            ed_sum += ed;
        end
        if (exact != 0) begin
            rel_sum += real'(ed) / real'(exact);
            rel_n++;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] base_hi;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset-state / zero operands.
        apply('0, '0);
        check("R4 zero result", 64'({cout_e, sum_e}), 64'd0);
        check("R1 zero result", 64'({cout_m, sum_m}), 64'd0);

        // Directed corners.
        run_vec(16'hFFFF, 16'hFFFF);
        run_vec(16'h0008, 16'h0008);   // guessed carry, over-estimate by 8
        check("R7 over-estimate", 64'({cout_m, sum_m}), 64'h18);
        run_vec(16'h0007, 16'h0001);   // missed carry, result 7 vs 8
        check("R7 under-estimate", 64'({cout_m, sum_m}), 64'h7);
        run_vec(16'hFFFF, 16'h0001);
        run_vec(16'h8000, 16'h8000);
        run_vec(16'h4000, 16'hC000);   // wide config carry from bit 14
        run_vec(16'h000A, 16'h0005);   // no overlap
        check("R5 disjoint", 64'({cout_m, sum_m}), 64'hF);

        // R3: bits below L-1 do not disturb the upper result.
        apply(16'hA5C8, 16'h3A08);
        base_hi = 64'({cout_m, sum_m}) >> LM;
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                apply(16'hA5C8 | 16'(i), 16'h3A08 | 16'(j));
                check("R3 upper insensitive", 64'({cout_m, sum_m}) >> LM, base_hi);
            end
        end

        // Constrained random: mix of free and overlap-free lower slices.
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] x, y;
            x = N'($urandom);
            y = N'($urandom);
            if (k % 4 == 0) y[LM-1:0] = y[LM-1:0] & ~x[LM-1:0];
            run_vec(x, y);
        end

        $display("monitor: wrong=%0d ed_total=%0d mean_red=%f", err_cnt, ed_sum,
                 (rel_n > 0) ? rel_sum / real'(rel_n) : 0.0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule